// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

This block runs while a chip is coming out of hard reset, before its processor core fetches any instruction. It walks a boot memory through a simple request/acknowledge byte-read port, takes one byte from the lowest byte lane of each response, and builds 32-bit configuration words from those bytes. The first word configures this device. The remaining seven words are kept for subordinate devices that share the boot memory.

Once the last byte has been taken, the block raises a one-cycle completion pulse and holds its results until the next reset. It presents its own word, an exception vector base picked by one bit of that word, and the address where the core starts executing. The subordinate words can be read through an indexed port. Because only the lowest lane is sampled, the width of the boot device's port does not change the result.

Top module: `rstcfg_loader`

## Requirements
- R1: After reset the block issues exactly 32 reads. Read n (starting at 0) uses byte address n*8.
- R2: A request holds memReq high and memAddr stable until memAck is sampled high on a rising clock edge. The byte is captured on that edge.
- R3: After each accepted read other than the last, memReq stays low for exactly WAIT_STATES cycles before the next request. The default is 2.
- R4: Only memData[7:0] is captured. All other data bits are ignored.
- R5: Read 4w+k (k = 0..3) is placed in bits [31-8k : 24-8k] of word w, so the first byte of a group becomes the most significant byte.
- R6: Word 0 appears on ownWord. subWord returns word subSel, where index 1..7 selects a subordinate word and index 0 selects the block's own word.
- R7: vectorBase is 0x00000000 when bit CIP_BIT of the own word is 0, and 0xFFF00000 when it is 1. CIP_BIT defaults to 8, counted from the LSB. resetPc equals vectorBase + 0x100.
- R8: done is high for exactly one cycle, in the cycle after the last read is accepted. cfgValid rises in that same cycle.
- R9: Once cfgValid is high, no further request is made, memAck has no effect, and every output stays stable until reset.
- R10: While reset is asserted, and until cfgValid rises, memReq, done, cfgValid, ownWord, subWord, vectorBase and resetPc are all 0.
- R11: A reset during a fetch abandons it. The next fetch starts again at address 0 and produces complete, correct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| memReq | output | 1 | Byte read request |
| memAddr | output | 32 | Byte address of the current read |
| memAck | input | 1 | Read acknowledge; data valid while high |
| memData | input | 64 | Read data; only bits [7:0] are used |
| subSel | input | 3 | Word index for the read port |
| subWord | output | 32 | Word selected by subSel |
| ownWord | output | 32 | The block's own configuration word |
| vectorBase | output | 32 | Selected exception vector base |
| resetPc | output | 32 | First instruction address |
| done | output | 1 | One-cycle completion pulse |
| cfgValid | output | 1 | Configuration outputs valid |

## Verification
The assertions assume the memory raises memAck only while memReq is high, and holds it for a single cycle per request. They also assume reset is asserted from time zero. The bench's memory model follows these rules. It answers after a chosen latency and drops memAck on the cycle after each acceptance. The only exception is a deliberate phase after completion, where the model forces memAck high to show that the block ignores it. The model fills the upper data lanes with a fixed non-zero pattern so that a wrong-lane capture would show up in the assembled words.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;
  localparam int IDX_FIELD_W = 8;

  typedef struct packed {
    logic                   capture;
    logic [IDX_FIELD_W-1:0] readIdx;
    logic                   hold;
  } fetchStrobes_t;
endpackage

// File: rtl/rstcfg_ctrl.sv
module rstcfg_ctrl
  import rstcfg_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_READS   = 32,
  parameter int STRIDE      = 8,
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memAck,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              done,
  output fetchStrobes_t     strobes
);
  localparam int CNT_W    = $clog2(NUM_READS);
  localparam int GAP_W    = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
  localparam int GAP_LAST = (WAIT_STATES > 0) ? WAIT_STATES - 1 : 0;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP, ST_DONE} fetchState_t;

  fetchState_t      state;
  logic [CNT_W-1:0] readCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [ADDR_W-1:0] addrReg;
  logic             accept;
  logic             lastRead;

  assign accept   = (state == ST_REQ) && memAck;
  assign lastRead = (readCnt == CNT_W'(NUM_READS - 1));
  assign memReq   = (state == ST_REQ);
  assign memAddr  = addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      readCnt <= '0;
      gapCnt  <= '0;
      addrReg <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: state <= ST_REQ;
        ST_REQ: begin
          if (memAck) begin
            if (lastRead) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end else begin
              readCnt <= readCnt + CNT_W'(1);
              addrReg <= addrReg + ADDR_W'(STRIDE);
              gapCnt  <= '0;
              state   <= (WAIT_STATES == 0) ? ST_REQ : ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(GAP_LAST)) state <= ST_REQ;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = accept;
    strobes.readIdx = IDX_FIELD_W'(readCnt);
    strobes.hold    = (state == ST_DONE);
  end

  // R2: an unanswered request keeps its address on the next cycle
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: once held, the port stays quiet
  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> (!memReq && !strobes.capture));

  generate
    if (WAIT_STATES > 0) begin : g_gapCheck
      // R3: an accepted read is followed by an idle cycle
      assert_gap_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
        (memReq && memAck) |=> !memReq);
    end
  endgenerate
endmodule

// File: rtl/rstcfg_datapath.sv
module rstcfg_datapath
  import rstcfg_pkg::*;
#(
  parameter int          DATA_W      = 64,
  parameter int          NUM_WORDS   = 8,
  parameter int          CIP_BIT     = 8,
  parameter logic [31:0] HIGH_BASE   = 32'hFFF0_0000,
  parameter logic [31:0] RESET_OFFS  = 32'h0000_0100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fetchStrobes_t                strobes,
  input  logic [DATA_W-1:0]            memData,
  input  logic [$clog2(NUM_WORDS)-1:0] subSel,
  output logic [31:0]                  subWord,
  output logic [31:0]                  ownWord,
  output logic [31:0]                  vectorBase,
  output logic [31:0]                  resetPc
);
  localparam int SEL_W = $clog2(NUM_WORDS);

  logic [31:0]      words [NUM_WORDS];
  logic [7:0]       byteIn;
  logic [SEL_W-1:0] wordSel;
  logic [1:0]       lanePos;

  assign byteIn  = memData[7:0];
  assign wordSel = strobes.readIdx[SEL_W+1:2];
  assign lanePos = strobes.readIdx[1:0];

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          words[w] <= '0;
        end else if (strobes.capture && (wordSel == SEL_W'(w))) begin
          unique case (lanePos)
            2'd0: words[w][31:24] <= byteIn;
            2'd1: words[w][23:16] <= byteIn;
            2'd2: words[w][15:8]  <= byteIn;
            default: words[w][7:0] <= byteIn;
          endcase
        end
      end
    end
  endgenerate

  always_comb begin
    ownWord    = strobes.hold ? words[0] : 32'h0;
    subWord    = strobes.hold ? words[subSel] : 32'h0;
    vectorBase = ownWord[CIP_BIT] ? HIGH_BASE : 32'h0;
    resetPc    = strobes.hold ? (vectorBase + RESET_OFFS) : 32'h0;
  end

  // R9: results do not move while held
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hold && $past(strobes.hold)) |-> ($stable(ownWord) && $stable(resetPc)));

  // R10: nothing is presented before the fetch completes
  assert_zero_until_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.hold |-> (ownWord == 32'h0 && resetPc == 32'h0));
endmodule

// File: rtl/rstcfg_loader.sv
module rstcfg_loader #(
  parameter int DATA_W      = 64,
  parameter int NUM_WORDS   = 8,
  parameter int STRIDE      = 8,
  parameter int WAIT_STATES = 2,
  parameter int CIP_BIT     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  output logic                         memReq,
  output logic [31:0]                  memAddr,
  input  logic                         memAck,
  input  logic [DATA_W-1:0]            memData,
  input  logic [$clog2(NUM_WORDS)-1:0] subSel,
  output logic [31:0]                  subWord,
  output logic [31:0]                  ownWord,
  output logic [31:0]                  vectorBase,
  output logic [31:0]                  resetPc,
  output logic                         done,
  output logic                         cfgValid
);
  localparam int NUM_READS = NUM_WORDS * 4;

  rstcfg_pkg::fetchStrobes_t strobes;

  rstcfg_ctrl #(
    .ADDR_W(32), .NUM_READS(NUM_READS), .STRIDE(STRIDE), .WAIT_STATES(WAIT_STATES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .memAck(memAck), .memReq(memReq),
    .memAddr(memAddr), .done(done), .strobes(strobes)
  );

  rstcfg_datapath #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .CIP_BIT(CIP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memData(memData),
    .subSel(subSel), .subWord(subWord), .ownWord(ownWord),
    .vectorBase(vectorBase), .resetPc(resetPc)
  );

  assign cfgValid = strobes.hold;
endmodule

// File: tb/rstcfg_loader_test.sv
module rstcfg_loader_test;
  localparam int WAITN = 2;
  localparam int CIPB  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [63:0] memData = '0;
  logic [2:0]  subSel = '0;
  logic [31:0] subWord, ownWord, vectorBase, resetPc;
  logic        done, cfgValid;

  int checks = 0, failures = 0;
  int cyc = 0, latency = 0, waitCnt = 0, nAcc = 0, lowCnt = 0;
  int addrErrs = 0, gapErrs = 0, stabErrs = 0, doneCount = 0, reqAfterDone = 0;
  int doneCycle = 0, lastAcceptCycle = 0;
  bit haveAcc = 0, prevReq = 0, fresh = 0, forceAck = 0;
  logic [31:0] holdAddr = '0;
  logic [31:0] image [8];

  always #10 clk = ~clk;

  rstcfg_loader #(.WAIT_STATES(WAITN), .CIP_BIT(CIPB)) uut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memData(memData), .subSel(subSel), .subWord(subWord), .ownWord(ownWord),
    .vectorBase(vectorBase), .resetPc(resetPc), .done(done), .cfgValid(cfgValid)
  );

  function automatic logic [7:0] imgByte(int n);
    if (n > 31) return 8'h00;
    return 8'((image[n/4] >> (8 * (3 - n % 4))) & 32'hFF);
  endfunction

  // memory model, acts on falling edges
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      memAck = 1'b0; waitCnt = 0; nAcc = 0; haveAcc = 0; lowCnt = 0; prevReq = 0;
    end else begin
      fresh = 0;
      if (done) begin doneCount++; doneCycle = cyc; end
      if (cfgValid && memReq) reqAfterDone++;
      if (memAck && !forceAck) begin memAck = 1'b0; fresh = 1; end
      if (memReq) begin
        if (!prevReq || fresh) begin
          if (haveAcc && lowCnt != WAITN) gapErrs++;
          lowCnt = 0; holdAddr = memAddr;
        end else if (memAddr != holdAddr) stabErrs++;
      end else lowCnt++;
      prevReq = memReq;
      if (memReq && !memAck && !forceAck) begin
        if (waitCnt >= latency) begin
          if (memAddr != 32'(nAcc * 8)) addrErrs++;
          memData = {56'hC3C3_C3C3_C3C3_C3, imgByte(nAcc)};
          memAck = 1'b1; lastAcceptCycle = cyc; nAcc++; haveAcc = 1; waitCnt = 0;
        end else waitCnt++;
      end
      if (forceAck) begin memAck = 1'b1; memData = 64'hFFFF_FFFF_FFFF_FF5A; end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    addrErrs = 0; gapErrs = 0; stabErrs = 0; doneCount = 0; reqAfterDone = 0;
    rstN = 1'b1;
  endtask

  task automatic waitValid();
    while (!cfgValid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkResults(string tag);
    check(addrErrs == 0, "R1", {tag, " address sequence"}, 32'(addrErrs), 0);
    check(nAcc == 32, "R1", {tag, " read count"}, 32'(nAcc), 32);
    check(gapErrs == 0, "R3", {tag, " idle gap"}, 32'(gapErrs), 0);
    check(stabErrs == 0, "R2", {tag, " address hold"}, 32'(stabErrs), 0);
    check(ownWord == image[0], "R5", {tag, " own word"}, ownWord, image[0]);
    for (int k = 1; k < 8; k++) begin
      subSel = 3'(k);
      #1;
      check(subWord == image[k], "R6", {tag, " subordinate word"}, subWord, image[k]);
    end
    subSel = 3'd0;
    #1;
    check(subWord == image[0], "R6", {tag, " index 0"}, subWord, image[0]);
    check(vectorBase == (image[0][CIPB] ? 32'hFFF0_0000 : 32'h0), "R7", {tag, " vector base"},
          vectorBase, image[0][CIPB] ? 32'hFFF0_0000 : 32'h0);
    check(resetPc == (image[0][CIPB] ? 32'hFFF0_0100 : 32'h100), "R7", {tag, " start address"},
          resetPc, image[0][CIPB] ? 32'hFFF0_0100 : 32'h100);
    check(doneCount == 1, "R8", {tag, " done pulses"}, 32'(doneCount), 1);
    check(doneCycle == lastAcceptCycle + 1, "R8", {tag, " done timing"},
          32'(doneCycle), 32'(lastAcceptCycle + 1));
  endtask

  task automatic testResetState();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(!memReq && !done && !cfgValid, "R10", "control in reset", {29'b0, memReq, done, cfgValid}, 0);
    check(ownWord == 0 && subWord == 0, "R10", "words in reset", ownWord | subWord, 0);
    check(vectorBase == 0 && resetPc == 0, "R10", "addresses in reset", resetPc, 0);
  endtask

  task automatic testLowBase();
    image = '{32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h4B5A_6978,
              32'h8796_A5B4, 32'hC3D2_E1F0, 32'h0102_0304, 32'hFEDC_BA98};
    latency = 0;
    applyReset();
    repeat (5) @(negedge clk);
    check(!cfgValid && ownWord == 0, "R10", "outputs before completion", ownWord, 0);
    waitValid();
    checkResults("fast memory");
  endtask

  task automatic testHighBase();
    image = '{32'hA5C3_0100, 32'h6543_2110, 32'hF0E1_D2C3, 32'hB4A5_9687,
              32'h7869_5A4B, 32'h3C2D_1E0F, 32'hFEFD_FCFB, 32'h0123_4567};
    latency = 3;
    applyReset();
    waitValid();
    checkResults("slow memory, R4 upper lanes");
  endtask

  task automatic testHoldAfterDone();
    logic [31:0] keep;
    keep = ownWord;
    forceAck = 1;
    repeat (10) @(negedge clk);
    forceAck = 0;
    @(negedge clk);
    check(reqAfterDone == 0, "R9", "requests after done", 32'(reqAfterDone), 0);
    check(ownWord == keep && cfgValid, "R9", "held word", ownWord, keep);
    check(doneCount == 1, "R9", "no extra done", 32'(doneCount), 1);
  endtask

  task automatic testMidReset();
    latency = 1;
    applyReset();
    while (nAcc < 10) @(negedge clk);
    applyReset();
    waitValid();
    checkResults("R11 restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    testResetState();
    testLowBase();
    testHoldAfterDone();
    testHighBase();
    testHoldAfterDone();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule